// File: doc/BRIEF.md
# Dispatch Resource Credit Limiter

This block sits beside a rename stage and decides, every cycle, how many of the instructions waiting at rename may be sent on. Three downstream structures report their free space: the reorder buffer, the issue queue and the load/store queue. The block keeps each of the last reported free counts. It also keeps a count of instructions that have been renamed but not yet dispatched. From these it works out how much room each structure really has this cycle.

The structure with the least room limits the group. If it has no room, nothing goes out and a block is requested. If it has some room but less than the waiting group needs, the group is cut to fit and a block is still requested for this cycle. Either way, a one-hot indicator names the structure that caused the limit, and that structure's saturating event counter advances. The rename stage reports back how many instructions it actually renamed, and dispatch reports how many left. The block uses these two counts to keep its in-flight count up to date.

Top module: `credit_limiter`

## Requirements
- R1: After reset the allowed count is 0, block is low, the source indicator is 0, the in-flight count is 0, the empty flag is 1 and all three event counters are 0.
- R2: Reorder-buffer room and issue-queue room each equal the stored free count minus (in-flight count minus `disp_cnt`).
- R3: Load/store-queue room equals its stored free count minus (in-flight count minus `disp_lsq_cnt`); `disp_cnt` does not enter it.
- R4: The limiting source starts as the reorder buffer. The issue queue takes over only if its room is strictly smaller. The load/store queue then takes over only if its room is strictly smaller than the current minimum. `full_src` is one-hot: bit 0 is the reorder buffer, bit 1 the issue queue, bit 2 the load/store queue.
- R5: With instructions waiting and a minimum room of zero or less, the allowed count is 0, block is high and `full_src` names the limiting source.
- R6: With instructions waiting and a minimum room that is positive but below the waiting count, the allowed count equals the minimum, block is high and `full_src` names the limiting source.
- R7: With a minimum room at or above the waiting count, the allowed count equals the waiting count, block is low and `full_src` is 0.
- R8: With no instructions waiting, the allowed count is 0, block is low, `full_src` is 0 and no event counter moves.
- R9: At each clock edge, the event counter of the source named in `full_src` increases by one, and it holds at its all-ones value.
- R10: At each clock edge the in-flight count becomes its value plus `renamed_cnt` minus `disp_cnt`. It is floored at 0 and held at its all-ones value.
- R11: A stored free count is replaced only in a cycle when its update flag is high. The empty flag is captured only together with the reorder-buffer count.
- R12: A waiting count above WIDTH is treated as WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rob_upd | input | 1 | Reorder-buffer report valid |
| rob_free_in | input | CNT_W | Reported reorder-buffer free entries |
| rob_empty_in | input | 1 | Reported reorder-buffer empty |
| iq_upd | input | 1 | Issue-queue report valid |
| iq_free_in | input | CNT_W | Reported issue-queue free entries |
| lsq_upd | input | 1 | Load/store-queue report valid |
| lsq_free_in | input | CNT_W | Reported load/store-queue free entries |
| disp_cnt | input | NW_W | Instructions dispatched this cycle |
| disp_lsq_cnt | input | NW_W | Instructions dispatched to the load/store queue this cycle |
| renamed_cnt | input | NW_W | Instructions renamed this cycle |
| avail_cnt | input | NW_W | Instructions waiting at rename |
| allow_cnt | output | NW_W | Instructions that may be renamed this cycle |
| block_req | output | 1 | Block request towards the previous stage |
| full_src | output | 3 | One-hot limiting source |
| rob_empty | output | 1 | Stored reorder-buffer empty flag |
| inflight | output | INFL_W | Renamed but not yet dispatched count |
| rob_full_evt | output | EVT_W | Reorder-buffer full events |
| iq_full_evt | output | EVT_W | Issue-queue full events |
| lsq_full_evt | output | EVT_W | Load/store-queue full events |

## Verification
The assertions check several properties on every cycle. The allowed count never exceeds the waiting count or WIDTH, and is below the waiting count whenever it is cut. A block always names exactly one source, and an idle cycle raises nothing. The event counters never decrease. The empty flag holds while no report arrives, and the in-flight count never rises on a cycle that only dispatches. Some behaviour can only be shown by the bench's scenarios. These are the exact room arithmetic, and in particular the separate load/store dispatch count. Also the strict tie-break order and the exact event totals, including saturation.

// File: rtl/credit_limiter.sv
module credit_limiter #(
  parameter int CNT_W  = 6,
  parameter int INFL_W = 6,
  parameter int WIDTH  = 4,
  parameter int EVT_W  = 16,
  localparam int NW_W  = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rob_upd,
  input  logic [CNT_W-1:0]  rob_free_in,
  input  logic              rob_empty_in,
  input  logic              iq_upd,
  input  logic [CNT_W-1:0]  iq_free_in,
  input  logic              lsq_upd,
  input  logic [CNT_W-1:0]  lsq_free_in,
  input  logic [NW_W-1:0]   disp_cnt,
  input  logic [NW_W-1:0]   disp_lsq_cnt,
  input  logic [NW_W-1:0]   renamed_cnt,
  input  logic [NW_W-1:0]   avail_cnt,
  output logic [NW_W-1:0]   allow_cnt,
  output logic              block_req,
  output logic [2:0]        full_src,
  output logic              rob_empty,
  output logic [INFL_W-1:0] inflight,
  output logic [EVT_W-1:0]  rob_full_evt,
  output logic [EVT_W-1:0]  iq_full_evt,
  output logic [EVT_W-1:0]  lsq_full_evt
);

  localparam int S  = ((CNT_W > INFL_W) ? CNT_W : INFL_W) + 2;
  localparam int IW = INFL_W + 2;

  logic [CNT_W-1:0]  rob_q, iq_q, lsq_q;
  logic              rob_empty_q;
  logic [INFL_W-1:0] inflight_q;
  logic [EVT_W-1:0]  evt_q [3];

  logic signed [S-1:0] rob_room, iq_room, lsq_room, room_min, avail_s;
  logic [2:0]          lim_src;
  logic [NW_W-1:0]     avail_eff;
  logic signed [IW-1:0] inf_sum;

  assign avail_eff = (avail_cnt > NW_W'(WIDTH)) ? NW_W'(WIDTH) : avail_cnt;
  assign avail_s   = S'(avail_eff);

  assign rob_room = S'(rob_q) - (S'(inflight_q) - S'(disp_cnt));
  assign iq_room  = S'(iq_q)  - (S'(inflight_q) - S'(disp_cnt));
  assign lsq_room = S'(lsq_q) - (S'(inflight_q) - S'(disp_lsq_cnt));

  always_comb begin
    room_min = rob_room;
    lim_src  = 3'b001;
    if (iq_room < room_min) begin
      room_min = iq_room;
      lim_src  = 3'b010;
    end
    if (lsq_room < room_min) begin
      room_min = lsq_room;
      lim_src  = 3'b100;
    end
  end

  always_comb begin
    allow_cnt = '0;
    block_req = 1'b0;
    full_src  = 3'b000;
    if (avail_eff != '0) begin
      if (room_min[S-1] || room_min == '0) begin
        block_req = 1'b1;
        full_src  = lim_src;
      end else if (room_min < avail_s) begin
        allow_cnt = room_min[NW_W-1:0];
        block_req = 1'b1;
        full_src  = lim_src;
      end else begin
        allow_cnt = avail_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rob_q       <= '0;
      iq_q        <= '0;
      lsq_q       <= '0;
      rob_empty_q <= 1'b1;
    end else begin
      if (rob_upd) begin
        rob_q       <= rob_free_in;
        rob_empty_q <= rob_empty_in;
      end
      if (iq_upd)  iq_q  <= iq_free_in;
      if (lsq_upd) lsq_q <= lsq_free_in;
    end
  end

  assign inf_sum = IW'(inflight_q) + IW'(renamed_cnt) - IW'(disp_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                inflight_q <= '0;
    else if (inf_sum[IW-1])    inflight_q <= '0;
    else if (inf_sum[INFL_W])  inflight_q <= '1;
    else                       inflight_q <= inf_sum[INFL_W-1:0];
  end

  for (genvar g = 0; g < 3; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          evt_q[g] <= '0;
      else if (full_src[g] && evt_q[g] != '1) evt_q[g] <= evt_q[g] + 1'b1;
    end
  end

  assign rob_empty    = rob_empty_q;
  assign inflight     = inflight_q;
  assign rob_full_evt = evt_q[0];
  assign iq_full_evt  = evt_q[1];
  assign lsq_full_evt = evt_q[2];

  assert_allow_le_avail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    allow_cnt <= avail_cnt && allow_cnt <= NW_W'(WIDTH));

  assert_cut_below_avail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (block_req && allow_cnt != '0) |-> allow_cnt < avail_cnt);

  assert_src_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    block_req |-> $countones(full_src) == 1);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_cnt == '0) |-> (!block_req && full_src == 3'b000));

  assert_evt_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rob_full_evt >= $past(rob_full_evt) && iq_full_evt >= $past(iq_full_evt)
              && lsq_full_evt >= $past(lsq_full_evt)));

  assert_empty_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rob_upd |=> $stable(rob_empty));

  assert_drain_no_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (renamed_cnt == '0) |=> inflight <= $past(inflight));

endmodule

// File: tb/credit_limiter_tb.sv
module credit_limiter_tb;
  localparam int CNT_W = 6, INFL_W = 6, WIDTH = 4, EVT_W = 3;
  localparam int NW_W = $clog2(WIDTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rob_upd = 0, iq_upd = 0, lsq_upd = 0, rob_empty_in = 1;
  logic [CNT_W-1:0] rob_free_in = '0, iq_free_in = '0, lsq_free_in = '0;
  logic [NW_W-1:0] disp_cnt = '0, disp_lsq_cnt = '0, renamed_cnt = '0, avail_cnt = '0;
  logic [NW_W-1:0] allow_cnt;
  logic block_req, rob_empty;
  logic [2:0] full_src;
  logic [INFL_W-1:0] inflight;
  logic [EVT_W-1:0] rob_full_evt, iq_full_evt, lsq_full_evt;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  credit_limiter #(.CNT_W(CNT_W), .INFL_W(INFL_W), .WIDTH(WIDTH), .EVT_W(EVT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rob_upd(rob_upd), .rob_free_in(rob_free_in), .rob_empty_in(rob_empty_in),
    .iq_upd(iq_upd), .iq_free_in(iq_free_in),
    .lsq_upd(lsq_upd), .lsq_free_in(lsq_free_in),
    .disp_cnt(disp_cnt), .disp_lsq_cnt(disp_lsq_cnt),
    .renamed_cnt(renamed_cnt), .avail_cnt(avail_cnt),
    .allow_cnt(allow_cnt), .block_req(block_req), .full_src(full_src),
    .rob_empty(rob_empty), .inflight(inflight),
    .rob_full_evt(rob_full_evt), .iq_full_evt(iq_full_evt), .lsq_full_evt(lsq_full_evt)
  );

  // vector table: stored free counts, waiting count, expected allow/block/source
  localparam int NV = 10;
  localparam int V_ROB [NV] = '{10, 2, 5, 5, 2, 5, 0, 4, 6, 3};
  localparam int V_IQ  [NV] = '{10, 5, 2, 6, 2, 3, 4, 4, 6, 9};
  localparam int V_LSQ [NV] = '{10, 6, 6, 1, 2, 3, 4, 0, 6, 9};
  localparam int V_AV  [NV] = '{ 3, 4, 4, 4, 4, 4, 2, 2, 7, 3};
  localparam int V_AL  [NV] = '{ 3, 2, 2, 1, 2, 3, 0, 0, 4, 3};
  localparam int V_BL  [NV] = '{ 0, 1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int V_SRC [NV] = '{ 0, 1, 2, 4, 1, 2, 1, 4, 0, 0};
  localparam string V_REQ [NV] = '{"R7", "R6", "R4", "R4", "R4", "R4", "R5", "R5", "R12", "R7"};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int r, input int i, input int l, input logic e);
    @(negedge clk);
    rob_upd = 1; iq_upd = 1; lsq_upd = 1;
    rob_free_in = CNT_W'(r); iq_free_in = CNT_W'(i); lsq_free_in = CNT_W'(l);
    rob_empty_in = e; avail_cnt = '0; disp_cnt = '0; disp_lsq_cnt = '0; renamed_cnt = '0;
    @(negedge clk);
    rob_upd = 0; iq_upd = 0; lsq_upd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    chk("R1 allow", int'(allow_cnt), 0);
    chk("R1 block", int'(block_req), 0);
    chk("R1 src", int'(full_src), 0);
    chk("R1 inflight", int'(inflight), 0);
    chk("R1 empty", int'(rob_empty), 1);
    chk("R1 events", int'(rob_full_evt) + int'(iq_full_evt) + int'(lsq_full_evt), 0);

    // R8: all rooms are 0 but nothing is waiting
    @(negedge clk); #2;
    chk("R8 block", int'(block_req), 0);
    chk("R8 src", int'(full_src), 0);
    @(negedge clk); #2;
    chk("R8 no event", int'(rob_full_evt), 0);

    for (int k = 0; k < NV; k++) begin
      load(V_ROB[k], V_IQ[k], V_LSQ[k], 1'b1);
      avail_cnt = NW_W'(V_AV[k]);
      #2;
      chk({V_REQ[k], " allow"}, int'(allow_cnt), V_AL[k]);
      chk({V_REQ[k], " block"}, int'(block_req), V_BL[k]);
      chk({V_REQ[k], " src"}, int'(full_src), V_SRC[k]);
    end
    @(negedge clk); avail_cnt = '0; #2;
    chk("R9 rob events", int'(rob_full_evt), 3);
    chk("R9 iq events", int'(iq_full_evt), 2);
    chk("R9 lsq events", int'(lsq_full_evt), 2);

    // in-flight tracking and room arithmetic
    load(6, 7, 5, 1'b0);
    chk("R11 empty captured", int'(rob_empty), 0);
    renamed_cnt = 3;
    @(negedge clk); renamed_cnt = 0; #2;
    chk("R10 inflight add", int'(inflight), 3);
    avail_cnt = 4; #2;
    chk("R3 lsq limits", int'(allow_cnt), 2);
    chk("R3 lsq src", int'(full_src), 4);
    @(negedge clk); disp_lsq_cnt = 2; #2;
    chk("R2 rob limits", int'(allow_cnt), 3);
    chk("R2 rob src", int'(full_src), 1);
    @(negedge clk); disp_lsq_cnt = 0; disp_cnt = 2; #2;
    chk("R3 lsq ignores disp", int'(allow_cnt), 2);
    chk("R3 lsq src again", int'(full_src), 4);
    @(negedge clk); disp_cnt = 0; avail_cnt = 0; #2;
    chk("R10 inflight sub", int'(inflight), 1);
    disp_cnt = 3;
    @(negedge clk); disp_cnt = 0; #2;
    chk("R10 floor at zero", int'(inflight), 0);
    renamed_cnt = 4; disp_cnt = 1;
    @(negedge clk); renamed_cnt = 0; disp_cnt = 0; #2;
    chk("R10 net change", int'(inflight), 3);

    // R11: reports without update flags are ignored
    rob_free_in = '0; iq_free_in = '0; lsq_free_in = '0; rob_empty_in = 1;
    @(negedge clk); @(negedge clk);
    avail_cnt = 4; #2;
    chk("R11 hold empty", int'(rob_empty), 0);
    chk("R11 hold counts", int'(allow_cnt), 2);
    avail_cnt = 0;

    // R9 saturation
    load(0, 9, 9, 1'b1);
    avail_cnt = 1;
    repeat (10) @(negedge clk);
    avail_cnt = 0; #2;
    chk("R9 saturate", int'(rob_full_evt), 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule